// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Sequencer

This block is the device-side control for a byte-wide, page-written nonvolatile memory model. A host drives chip enable, output enable, write enable, a 17-bit address and an 8-bit data bus. The block samples all of them in one clock domain. It collects byte loads into a 128-byte page buffer for as long as the host keeps loading, and closes the load window once the bus has been quiet for a set number of cycles. It then runs a timed internal write that commits the whole page to a behavioral array. While that write runs, reads return status instead of array data.

The upper ten address bits select the page and the low seven select the byte within it. The page that gets written is the page of the last byte loaded. Buffer slots that were never loaded are written as FFh. The behavioral array holds `MODEL_PAGES` pages, chosen by the low page-address bits. All timings are parameters counted in clock cycles.

Top module: `page_write_seq`

## Requirements
- R1: After reset `busy`, `wr_done`, `dout_en` and `dout` are all 0.
- R2: Address bits [6:0] pick the byte in a page and bits [16:7] pick the page. The array stores the page selected by the low log2(MODEL_PAGES) page bits, and a read after the write returns the byte stored at that address.
- R3: A load whose write strobe begins less than `CLOSE_CYC` cycles after the previous strobe ended keeps the load window open, and no write starts.
- R4: Once `CLOSE_CYC` cycles pass after the last strobe ends with no new strobe, `busy` rises. It stays high for exactly `WRITE_CYC` cycles. `wr_done` then pulses for exactly one cycle, in the cycle `busy` falls.
- R5: Every byte of the written page that was not loaded reads back as FFh.
- R6: Loading a byte offset again replaces its data. The destination page is the page of the last byte loaded, even if earlier bytes named another page.
- R7: A strobe while output enable is low, or an active strobe shorter than `GLITCH_CYC` sampled cycles, loads nothing and starts no write.
- R8: While `busy` is high, a read returns bit 7 as the complement of the last loaded byte's bit 7, bit 6 as a toggle that reads 1 on the first read and alternates on each later read, and bits [5:0] from the last loaded byte. Array data is never returned.
- R9: Byte loads made while `busy` is high are discarded and start no further write.
- R10: The address is taken when the strobe (chip enable and write enable both low) begins. The data is taken when the strobe ends. Address changes in the middle of a strobe are ignored, and the last data value before release is the one stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Byte address; [16:7] page, [6:0] offset |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or busy status |
| dout_en | output | 1 | High while a read is being served |
| busy | output | 1 | Internal write in progress |
| wr_done | output | 1 | One-cycle pulse when the internal write ends |

## Verification
The hardest case to reach is the busy phase, because the status read pattern and the dropped loads exist only inside the `WRITE_CYC` window that follows the idle timeout. The stimulus arranges it by timing. It loads a page with short gaps, waits past `CLOSE_CYC`, and then fits three status reads and one stray load into the window. A later readback shows that the stray byte never reached the array. Mid-strobe address and data changes, and strobes that are too short or masked by output enable, are aimed at one page. That page's final contents show which values were kept.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int unsigned ADDR_W  = 17;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OFF_W   = 7;
  localparam int unsigned PAGE_SZ = 1 << OFF_W;
  localparam logic [DATA_W-1:0] ERASED = 8'hFF;

  typedef logic [PAGE_SZ-1:0][DATA_W-1:0] page_buf_t;
endpackage

// File: rtl/pw_strobe.sv
module pw_strobe
  import pw_pkg::*;
#(
  parameter int unsigned GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ld_start,
  output logic              ld_fire,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              wr_act,
  output logic              rd_act,
  output logic              rd_start,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int unsigned GW = $clog2(GLITCH_CYC + 1);

  logic [2:0]        ctl_s1, ctl_s2;
  logic [ADDR_W-1:0] adr_s1, adr_s2;
  logic [DATA_W-1:0] dat_s1, dat_s2, dat_q;
  logic              act, act_q, rd, rd_q;
  logic [GW-1:0]     len_q, len_d;
  logic [ADDR_W-1:0] ladr_q, ladr_d;

  // two-stage synchronizer on every bus input, aligned
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= 3'b111;
      ctl_s2 <= 3'b111;
      adr_s1 <= '0;
      adr_s2 <= '0;
      dat_s1 <= '0;
      dat_s2 <= '0;
    end else begin
      ctl_s1 <= {ce_n, oe_n, we_n};
      ctl_s2 <= ctl_s1;
      adr_s1 <= addr;
      adr_s2 <= adr_s1;
      dat_s1 <= din;
      dat_s2 <= dat_s1;
    end
  end

  // write strobe: chip and write enable low, output enable high
  assign act = !ctl_s2[2] && ctl_s2[1] && !ctl_s2[0];
  assign rd  = !ctl_s2[2] && !ctl_s2[1];

  always_comb begin
    len_d  = len_q;
    ladr_d = ladr_q;
    if (!act) len_d = '0;
    else if (len_q < GW'(GLITCH_CYC)) len_d = len_q + 1'b1;
    if (act && !act_q) ladr_d = adr_s2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      rd_q   <= 1'b0;
      len_q  <= '0;
      ladr_q <= '0;
      dat_q  <= '0;
    end else begin
      act_q  <= act;
      rd_q   <= rd;
      len_q  <= len_d;
      ladr_q <= ladr_d;
      dat_q  <= dat_s2;
    end
  end

  assign ld_start = act && !act_q;
  assign ld_fire  = !act && act_q && (len_q >= GW'(GLITCH_CYC));
  assign ld_addr  = ladr_q;
  assign ld_data  = dat_q;
  assign wr_act   = act;
  assign rd_act   = rd;
  assign rd_start = rd && !rd_q;
  assign rd_addr  = adr_s2;

  // a load only follows a strobe that lasted the glitch threshold
  p_fire_after_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> $past(act) && $past(len_q) >= GW'(GLITCH_CYC - 1));
  p_no_fire_in_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fire |-> !$past(rd));
endmodule

// File: rtl/pw_loadctl.sv
module pw_loadctl
  import pw_pkg::*;
#(
  parameter int unsigned CLOSE_CYC = 40,
  parameter int unsigned PG_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_start,
  input  logic              ld_fire,
  input  logic [OFF_W-1:0]  ld_off,
  input  logic [PG_W-1:0]   ld_pg,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              wr_act,
  input  logic              busy,
  input  logic              wr_done,
  output logic              commit,
  output logic [PG_W-1:0]   page,
  output page_buf_t         pbuf,
  output logic [PAGE_SZ-1:0] loaded,
  output logic [DATA_W-1:0] last
);
  localparam int unsigned TW = $clog2(CLOSE_CYC);

  logic              open_q, open_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              accept;
  page_buf_t         pbuf_d;
  logic [PAGE_SZ-1:0] ld_d;
  logic [PG_W-1:0]   page_d;
  logic [DATA_W-1:0] last_d;

  assign accept = ld_fire && !busy;
  assign commit = open_q && !busy && !wr_act && (tmr_q == TW'(CLOSE_CYC - 1));

  always_comb begin
    open_d = open_q;
    tmr_d  = tmr_q;
    pbuf_d = pbuf;
    ld_d   = loaded;
    page_d = page;
    last_d = last;
    if (wr_done) ld_d = '0;
    if (wr_act || ld_start) tmr_d = '0;
    else if (open_q) tmr_d = tmr_q + 1'b1;
    if (commit) begin
      open_d = 1'b0;
      tmr_d  = '0;
    end
    if (accept) begin
      pbuf_d[ld_off] = ld_data;
      ld_d[ld_off]   = 1'b1;
      page_d         = ld_pg;
      last_d         = ld_data;
      open_d         = 1'b1;
      tmr_d          = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
      loaded <= '0;
      page   <= '0;
      last   <= '0;
    end else begin
      open_q <= open_d;
      tmr_q  <= tmr_d;
      loaded <= ld_d;
      page   <= page_d;
      last   <= last_d;
    end
  end

  // page data needs no reset; validity is carried by the loaded mask
  always_ff @(posedge clk) begin
    if (accept) pbuf <= pbuf_d;
  end

  p_commit_starts_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy && !open_q);
  p_timer_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> tmr_q <= TW'(CLOSE_CYC - 1));
  p_busy_drops_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && busy) |=> $stable(loaded) || $past(wr_done));
endmodule

// File: rtl/pw_store.sv
module pw_store
  import pw_pkg::*;
#(
  parameter int unsigned WRITE_CYC   = 100,
  parameter int unsigned MODEL_PAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [$clog2(MODEL_PAGES)-1:0] page,
  input  page_buf_t         pbuf,
  input  logic [PAGE_SZ-1:0] loaded,
  input  logic              last_msb,
  input  logic [5:0]        last_low,
  input  logic              rd_act,
  input  logic              rd_start,
  input  logic [OFF_W+$clog2(MODEL_PAGES)-1:0] rd_idx,
  output logic              busy,
  output logic              wr_done,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int unsigned PB    = $clog2(MODEL_PAGES);
  localparam int unsigned DEPTH = MODEL_PAGES * PAGE_SZ;
  localparam int unsigned WW    = $clog2(WRITE_CYC);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [WW-1:0]     wcnt_q, wcnt_d;
  logic              busy_d, done_d, tgl_q, tgl_d, finish;
  logic [DATA_W-1:0] dout_d;

  assign finish = busy && (wcnt_q == WW'(WRITE_CYC - 1));

  always_comb begin
    busy_d = busy;
    wcnt_d = wcnt_q;
    done_d = 1'b0;
    tgl_d  = tgl_q;
    dout_d = dout;
    if (commit) begin
      busy_d = 1'b1;
      wcnt_d = '0;
      tgl_d  = 1'b1;
    end else if (finish) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end else if (busy) begin
      wcnt_d = wcnt_q + 1'b1;
    end
    if (!rd_act) begin
      dout_d = '0;
    end else if (busy) begin
      if (rd_start) begin
        dout_d = {~last_msb, tgl_q, last_low};
        tgl_d  = ~tgl_q;
      end
    end else begin
      dout_d = mem[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wcnt_q  <= '0;
      wr_done <= 1'b0;
      tgl_q   <= 1'b1;
      dout    <= '0;
      dout_en <= 1'b0;
    end else begin
      busy    <= busy_d;
      wcnt_q  <= wcnt_d;
      wr_done <= done_d;
      tgl_q   <= tgl_d;
      dout    <= dout_d;
      dout_en <= rd_act;
    end
  end

  // behavioral array: whole page committed at the end of the write
  always_ff @(posedge clk) begin
    if (finish) begin
      for (int i = 0; i < PAGE_SZ; i++) begin
        mem[{page, OFF_W'(i)}] <= loaded[i] ? pbuf[i] : ERASED;
      end
    end
  end

  p_done_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);
  p_done_with_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> wr_done);
  p_first_toggle_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> tgl_q);
  p_status_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_act && rd_start) |=> dout[7] == ~$past(last_msb));
  p_no_commit_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !busy);
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pw_pkg::*;
#(
  parameter int unsigned CLOSE_CYC   = 40,
  parameter int unsigned WRITE_CYC   = 100,
  parameter int unsigned GLITCH_CYC  = 2,
  parameter int unsigned MODEL_PAGES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [16:0] addr,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  output logic        dout_en,
  output logic        busy,
  output logic        wr_done
);
  localparam int unsigned PB = $clog2(MODEL_PAGES);

  logic              ld_start, ld_fire, wr_act, rd_act, rd_start, commit;
  logic [ADDR_W-1:0] ld_addr, rd_addr;
  logic [DATA_W-1:0] ld_data, last;
  logic [PB-1:0]     page;
  page_buf_t         pbuf;
  logic [PAGE_SZ-1:0] loaded;
  logic              unused_bits;

  assign unused_bits = ^{ld_addr[ADDR_W-1:OFF_W+PB], rd_addr[ADDR_W-1:OFF_W+PB], last[6]};

  pw_strobe #(.GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din),
    .ld_start(ld_start), .ld_fire(ld_fire), .ld_addr(ld_addr), .ld_data(ld_data),
    .wr_act(wr_act), .rd_act(rd_act), .rd_start(rd_start), .rd_addr(rd_addr)
  );

  pw_loadctl #(.CLOSE_CYC(CLOSE_CYC), .PG_W(PB)) u_loadctl (
    .clk(clk), .rst_n(rst_n), .ld_start(ld_start), .ld_fire(ld_fire),
    .ld_off(ld_addr[OFF_W-1:0]), .ld_pg(ld_addr[OFF_W +: PB]), .ld_data(ld_data),
    .wr_act(wr_act), .busy(busy), .wr_done(wr_done),
    .commit(commit), .page(page), .pbuf(pbuf), .loaded(loaded), .last(last)
  );

  pw_store #(.WRITE_CYC(WRITE_CYC), .MODEL_PAGES(MODEL_PAGES)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit), .page(page), .pbuf(pbuf),
    .loaded(loaded), .last_msb(last[7]), .last_low(last[5:0]),
    .rd_act(rd_act), .rd_start(rd_start), .rd_idx(rd_addr[OFF_W+PB-1:0]),
    .busy(busy), .wr_done(wr_done), .dout(dout), .dout_en(dout_en)
  );
endmodule

// File: tb/test_page_write_seq.sv
`timescale 1ns/1ps
module test_page_write_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [16:0] addr = '0;
  logic [7:0]  din = '0;
  logic [7:0]  dout;
  logic        dout_en, busy, wr_done;
  int          n_chk = 0, n_bad = 0;
  int          busy_cyc = 0, done_cnt = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  page_write_seq i_page_write_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .wr_done(wr_done)
  );

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (wr_done) done_cnt++;
  end

  // load vectors for page 5 (base 280h); byte 1 reloaded last
  localparam logic [16:0] L_ADR [5] = '{17'h280, 17'h281, 17'h2FF, 17'h285, 17'h281};
  localparam logic [7:0]  L_DAT [5] = '{8'h11, 8'h22, 8'h80, 8'h7F, 8'h99};
  // readback vectors after the write
  localparam logic [16:0] R_ADR [6] = '{17'h280, 17'h281, 17'h2FF, 17'h285, 17'h282, 17'h2C0};
  localparam logic [7:0]  R_EXP [6] = '{8'h11, 8'h99, 8'h80, 8'h7F, 8'hFF, 8'hFF};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [16:0] a, input logic [7:0] d, input int hold, input int gap);
    @(negedge clk);
    addr = a; din = d; we_n = 1'b0;
    repeat (hold) @(negedge clk);
    we_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic read(input logic [16:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    v = dout;
    oe_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 busy", {7'd0, busy}, 8'h00);
    check("R1 wr_done", {7'd0, wr_done}, 8'h00);
    check("R1 dout_en", {7'd0, dout_en}, 8'h00);
    check("R1 dout", dout, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    busy_cyc = 0; done_cnt = 0;
    for (int i = 0; i < 5; i++) load(L_ADR[i], L_DAT[i], 4, 10);
    repeat (10) @(negedge clk);
    check("R3 window still open", {7'd0, busy}, 8'h00);
    repeat (45) @(negedge clk);
    check("R4 busy after timeout", {7'd0, busy}, 8'h01);
    // R8 status reads: last byte 99h
    read(17'h281, v); check("R8 status read 1", v, 8'h59);
    read(17'h281, v); check("R8 status read 2", v, 8'h19);
    read(17'h280, v); check("R8 status read 3", v, 8'h59);
    // R9 load while busy must be dropped
    load(17'h282, 8'h33, 4, 4);
    wait_idle();
    repeat (80) @(negedge clk);
    check("R4 busy length", 8'(busy_cyc), 8'd100);
    check("R4 single done pulse", 8'(done_cnt), 8'd1);
    for (int i = 0; i < 6; i++) begin
      read(R_ADR[i], v);
      check("R2 R5 R6 R9 readback", v, R_EXP[i]);
    end

    // R6 destination from last byte loaded
    load(17'h10A, 8'hA1, 4, 10);
    load(17'h30B, 8'hB2, 4, 60);
    wait_idle();
    read(17'h30A, v); check("R6 page from last load", v, 8'hA1);
    read(17'h30B, v); check("R6 last byte", v, 8'hB2);
    read(17'h30C, v); check("R5 unloaded byte", v, 8'hFF);

    // R7 masked strobe and glitch into page 7
    busy_cyc = 0; done_cnt = 0;
    @(negedge clk); oe_n = 1'b0;
    load(17'h388, 8'h00, 5, 2);
    oe_n = 1'b1;
    load(17'h389, 8'h00, 1, 80);
    check("R7 no write started", {7'd0, busy}, 8'h00);
    check("R7 no done pulse", 8'(done_cnt), 8'd0);

    // R10 address at strobe start, data at strobe end
    @(negedge clk);
    addr = 17'h383; din = 8'h10; we_n = 1'b0;
    repeat (2) @(negedge clk);
    addr = 17'h384; din = 8'h5A;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (60) @(negedge clk);
    wait_idle();
    read(17'h383, v); check("R10 data at release", v, 8'h5A);
    read(17'h384, v); check("R10 mid-strobe address ignored", v, 8'hFF);
    read(17'h388, v); check("R7 masked strobe not loaded", v, 8'hFF);
    read(17'h389, v); check("R7 glitch not loaded", v, 8'hFF);
    read(17'h2FF, v); check("R2 other page intact", v, 8'h80);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule